// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches a group of off-chip interrupt pins and a bank of key-scan inputs and turns qualifying edges into sticky request flags. Every pin has its own edge rule. Two pins have a programmable edge. One pin reacts to rising edges only. One pin reacts to both edges. The key-scan pins react to falling edges. The primary interrupt pin also passes through a noise filter with a selectable minimum pulse width. The other pins are resynchronised to the system clock before their edges are detected. Three on-chip pulse sources set flags of their own as well.

There are two kinds of flag. Six vectored flags can be enabled one by one, and the highest-priority enabled flag is presented to the processor as a request with an identifier. Two polled-only flags are never presented as a request: one for the rising-edge pin and one shared by all key-scan pins. Software reads these flags and clears them. A small write port sets the edge polarities, the filter width, the vectored enables and the per-pin key mask, and clears flags. An acknowledge input removes the flag that is being presented.

Top module: `ext_irq_detector`

## Requirements
- R1: After reset all eight flags read 0, the request output is low, and all configuration fields are 0.
- R2: Writing address 0 sets the configuration. Bit 0 picks the edge for the primary pin: 1 selects rising, 0 selects falling. A filtered edge of the selected kind sets flag bit 0, and the other edge is ignored.
- R3: The primary pin changes its filtered level only after it has held the new level for W consecutive clocks. W is FILT_SHORT when configuration bit 2 is 0 and FILT_LONG when bit 2 is 1. Shorter pulses set no flag.
- R4: Configuration bit 1 picks the edge for the second pin (1 rising, 0 falling). A synchronised edge of the selected kind sets flag bit 1.
- R5: A rising edge on the polled pin sets flag bit 6. Its falling edge is ignored, and flag bit 6 never raises a request.
- R6: Both rising and falling edges on the dual-edge pin set flag bit 2.
- R7: A falling edge on key pin k sets flag bit 7 only when bit k of the key mask (address 2) is 1. Rising key edges are ignored, and flag bit 7 never raises a request.
- R8: A one-cycle pulse on on-chip source j (j = 0..2) sets flag bit 3+j on the next clock edge.
- R9: Address 1 bits 5:0 enable vectored flags 5:0. The request output is high exactly when some enabled vectored flag is set, and the identifier gives the lowest-numbered such flag.
- R10: An acknowledge while a request is presented clears only the presented flag.
- R11: Writing address 3 clears every flag whose data bit is 1. If a flag's set event and its clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int0_i | input | 1 | Primary filtered interrupt pin |
| int1_i | input | 1 | Second pin with selectable edge |
| int2_i | input | 1 | Polled rising-edge pin |
| int4_i | input | 1 | Dual-edge pin |
| key_i | input | 8 | Key-scan pins, falling edge |
| intern_i | input | 3 | On-chip interrupt pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Acknowledge of the presented request |
| flags_o | output | 8 | Pending flags |
| req_valid_o | output | 1 | Vectored request present |
| req_id_o | output | 3 | Index of the presented flag |

## Verification
The assertions assume that every pin input holds its level for at least one clock, and that the on-chip sources are single-cycle pulses aligned to the clock. The stimulus changes all inputs only at the falling clock edge, holds each pin level for several cycles, and raises each on-chip source for exactly one cycle. Filter pulses are chosen a few clocks to either side of each width, so that no check lands on the cycle where the filter switches.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int NUM_FLAGS = 8;
    localparam int NUM_VEC   = 6;
    localparam int ID_W      = 3;
    localparam int NUM_KEYS  = 8;
    localparam int NUM_INT   = 3;

    localparam int F_PRIM  = 0;
    localparam int F_SEC   = 1;
    localparam int F_DUAL  = 2;
    localparam int F_ONCHP = 3;
    localparam int F_POLL  = 6;
    localparam int F_KEY   = 7;

    typedef enum logic [1:0] {
        REG_CFG    = 2'd0,
        REG_ENABLE = 2'd1,
        REG_KEYMSK = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic prim_long;
        logic sec_rise;
        logic prim_rise;
    } cfg_t;

    function automatic logic [ID_W-1:0] first_set(input logic [NUM_VEC-1:0] v);
        logic [ID_W-1:0] id;
        id = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (v[i]) id = ID_W'(i);
        end
        return id;
    endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_pulse_filter.sv
module irq_pulse_filter #(
    parameter int SHORT_CYC = 8,
    parameter int LONG_CYC  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic long_sel,
    output logic level
);
    localparam int MAXW  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W = $clog2(MAXW + 1);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim = long_sel ? LIM_L : LIM_S;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
        end else if (din == level) begin
            cnt <= '0;
        end else if (cnt >= lim) begin
            level <= din;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/irq_edge.sv
module irq_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= d;
    end

    assign rise = d & ~prev;
    assign fall = ~d & prev;
endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
    import ext_irq_pkg::*;
#(
    parameter int FILT_SHORT = 8,
    parameter int FILT_LONG  = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 int0_i,
    input  logic                 int1_i,
    input  logic                 int2_i,
    input  logic                 int4_i,
    input  logic [NUM_KEYS-1:0]  key_i,
    input  logic [NUM_INT-1:0]   intern_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [7:0]           wr_data_i,
    input  logic                 ack_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 req_valid_o,
    output logic [ID_W-1:0]      req_id_o
);
    localparam int PIN_W = NUM_KEYS + 4;

    cfg_t                 cfg;
    logic [NUM_VEC-1:0]   vec_en;
    logic [NUM_KEYS-1:0]  key_mask;
    logic [PIN_W-1:0]     pin_raw;
    logic [PIN_W-1:0]     sync_q;
    logic                 prim_filt;
    logic [PIN_W-1:0]     edge_in;
    logic [PIN_W-1:0]     rise;
    logic [PIN_W-1:0]     fall;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_VEC-1:0]   pend;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            vec_en   <= '0;
            key_mask <= '0;
        end else if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                REG_CFG:    cfg      <= wr_data_i[2:0];
                REG_ENABLE: vec_en   <= wr_data_i[NUM_VEC-1:0];
                REG_KEYMSK: key_mask <= wr_data_i[NUM_KEYS-1:0];
                default:    ;
            endcase
        end
    end

    // bit order: {keys, dual, poll, second, primary}
    assign pin_raw = {key_i, int4_i, int2_i, int1_i, int0_i};

    irq_sync2 #(.W(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (sync_q)
    );

    irq_pulse_filter #(.SHORT_CYC(FILT_SHORT), .LONG_CYC(FILT_LONG)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .din      (sync_q[0]),
        .long_sel (cfg.prim_long),
        .level    (prim_filt)
    );

    assign edge_in = {sync_q[PIN_W-1:1], prim_filt};

    irq_edge #(.W(PIN_W)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .d    (edge_in),
        .rise (rise),
        .fall (fall)
    );

    always_comb begin
        set_v                        = '0;
        set_v[F_PRIM]                = cfg.prim_rise ? rise[0] : fall[0];
        set_v[F_SEC]                 = cfg.sec_rise  ? rise[1] : fall[1];
        set_v[F_DUAL]                = rise[3] | fall[3];
        set_v[F_ONCHP +: NUM_INT]    = intern_i;
        set_v[F_POLL]                = rise[2];
        set_v[F_KEY]                 = |(fall[PIN_W-1:4] & key_mask);
    end

    assign pend        = flags_o[NUM_VEC-1:0] & vec_en;
    assign req_valid_o = |pend;
    assign req_id_o    = first_set(pend);

    always_comb begin
        clr_v = '0;
        if (wr_en_i && reg_addr_e'(wr_addr_i) == REG_CLEAR) clr_v = wr_data_i;
        if (ack_i && req_valid_o) clr_v[req_id_o] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & ~clr_v) | set_v;
    end
endmodule

// File: rtl/irq_checker.sv
module irq_checker
    import ext_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_VEC-1:0]   en,
    input logic [NUM_KEYS-1:0]  kmask,
    input logic                 req_valid,
    input logic [ID_W-1:0]      req_id,
    input logic                 sync0,
    input logic                 filt0
);
    // R9
    presented_pending_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (flags[req_id] && en[req_id]));

    // R9
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((flags[NUM_VEC-1:0] & en & ((NUM_VEC'(1) << req_id) - NUM_VEC'(1))) == '0));

    // R5
    polled_never_vectored_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_id < ID_W'(NUM_VEC)));

    // R7
    key_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_KEY]) |-> ($past(kmask) != '0));

    // R3
    filter_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        (filt0 != $past(filt0)) |-> ($past(sync0) != $past(filt0)));
endmodule

bind ext_irq_detector irq_checker u_irq_checker (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags_o),
    .en        (vec_en),
    .kmask     (key_mask),
    .req_valid (req_valid_o),
    .req_id    (req_id_o),
    .sync0     (sync_q[0]),
    .filt0     (prim_filt)
);

// File: tb/test_ext_irq_detector.sv
module test_ext_irq_detector;
    localparam int WS = 8;
    localparam int WL = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       int0 = 0, int1 = 0, int2 = 0, int4 = 0;
    logic [7:0] key = 8'hFF;
    logic [2:0] intern = '0;
    logic       wr_en = 0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 0;
    logic [7:0] flags;
    logic       req_valid;
    logic [2:0] req_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_irq_detector #(.FILT_SHORT(WS), .FILT_LONG(WL)) i_ext_irq_detector (
        .clk(clk), .rst(rst), .int0_i(int0), .int1_i(int1), .int2_i(int2),
        .int4_i(int4), .key_i(key), .intern_i(intern), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
        .flags_o(flags), .req_valid_o(req_valid), .req_id_o(req_id)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    function automatic logic [2:0] exp_first(input logic [5:0] m);
        for (int i = 0; i < 6; i++) if (m[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic prim_pulse(input int len);
        int0 = 1; step(len); int0 = 0; step(len + 12);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst = 0;
        step(2);
        check("R1 flags", 32'(flags), 0);
        check("R1 req", 32'(req_valid), 0);

        // R2 primary edge selection (short filter)
        wr(0, 8'h01);
        int0 = 1; step(WS + 6);
        check("R2 rising sets", 32'(flags[0]), 1);
        wr(3, 8'h01);
        int0 = 0; step(WS + 6);
        check("R2 falling ignored", 32'(flags[0]), 0);
        wr(0, 8'h00);
        int0 = 1; step(WS + 6);
        check("R2 rising ignored", 32'(flags[0]), 0);
        int0 = 0; step(WS + 6);
        check("R2 falling sets", 32'(flags[0]), 1);
        wr(3, 8'hFF);

        // R3 filter widths
        wr(0, 8'h01);
        prim_pulse(WS - 2);
        check("R3 short reject", 32'(flags[0]), 0);
        prim_pulse(WS + 2);
        check("R3 short accept", 32'(flags[0]), 1);
        wr(3, 8'hFF);
        wr(0, 8'h05);
        prim_pulse(WL - 28);
        check("R3 long reject", 32'(flags[0]), 0);
        prim_pulse(WL + 12);
        check("R3 long accept", 32'(flags[0]), 1);
        wr(3, 8'hFF);

        // R4 second pin
        wr(0, 8'h02);
        int1 = 1; step(5);
        check("R4 rising sets", 32'(flags[1]), 1);
        wr(3, 8'hFF);
        int1 = 0; step(5);
        check("R4 falling ignored", 32'(flags[1]), 0);
        wr(0, 8'h00);
        int1 = 1; step(5);
        check("R4 rising ignored", 32'(flags[1]), 0);
        int1 = 0; step(5);
        check("R4 falling sets", 32'(flags[1]), 1);
        wr(3, 8'hFF);

        // R6 dual edge
        int4 = 1; step(5);
        check("R6 rise", 32'(flags[2]), 1);
        wr(3, 8'hFF);
        int4 = 0; step(5);
        check("R6 fall", 32'(flags[2]), 1);
        wr(3, 8'hFF);

        // R5 polled pin
        wr(1, 8'h3F);
        int2 = 1; step(5);
        check("R5 rise flag", 32'(flags[6]), 1);
        check("R5 no request", 32'(req_valid), 0);
        wr(3, 8'hFF);
        int2 = 0; step(5);
        check("R5 fall ignored", 32'(flags[6]), 0);

        // R7 key pins, random masks
        for (int i = 0; i < 12; i++) begin
            logic [7:0] m;
            int pin;
            m = 8'($urandom);
            pin = int'($urandom % 8);
            wr(2, m);
            key[pin] = 0; step(5);
            check("R7 key fall", 32'(flags[7]), 32'(m[pin]));
            check("R7 no request", 32'(req_valid), 0);
            wr(3, 8'hFF);
            key[pin] = 1; step(5);
            check("R7 key rise ignored", 32'(flags[7]), 0);
        end

        // R8 R9 R10 on-chip sources, random enables
        for (int i = 0; i < 16; i++) begin
            logic [2:0] v;
            logic [5:0] en, pm, after;
            v  = 3'($urandom);
            en = 6'($urandom);
            wr(1, {2'b00, en});
            intern = v; step(1); intern = 0;
            check("R8 flags", 32'(flags[5:3]), 32'(v));
            pm = {v, 3'b000} & en;
            check("R9 valid", 32'(req_valid), 32'(|pm));
            if (|pm) begin
                check("R9 id", 32'(req_id), 32'(exp_first(pm)));
                after = {v, 3'b000};
                after[exp_first(pm)] = 1'b0;
                ack = 1; step(1); ack = 0;
                check("R10 ack clears one", 32'(flags[5:0]), 32'(after));
            end
            wr(3, 8'hFF);
        end

        // R11 set wins over clear
        wr_en = 1; wr_addr = 2'd3; wr_data = 8'hFF; intern = 3'b001;
        step(1);
        wr_en = 0; intern = 0;
        check("R11 set wins", 32'(flags[3]), 1);
        wr(3, 8'h08);
        check("R11 clear", 32'(flags), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule